// File: doc/BRIEF.md
# One-wire master bit-slot timer

This block is the master-side line driver for a one-wire bus. It produces the three kinds of timed activity a master needs: a bus reset followed by a check for a responding device, write slots that carry a 0 or a 1, and read slots that sample the bit a device returns. The line is represented as an open-drain pull-down enable (`line_oe`, high means the master pulls the wire low) and a sampled copy of the wire level (`line_in`). All timing is counted in a microsecond clock-enable pulse (`us_tick`), so the system clock may be any rate above 1 MHz.

A client issues one operation at a time. It raises `req_valid` for a cycle with an operation code and, for writes, the bit to send. While the operation runs, `busy` is high. When it finishes, `done` pulses for one clock. The reset result is held on `presence` and the latest read bit is held on `rd_bit` until the next operation of the same kind replaces it. Byte assembly and the pull-up resistor lie outside the block.

Top module: `owire_slot_master`

## Requirements
- R1: After reset, `busy`, `done`, `line_oe`, `presence` and `rd_bit` are all 0.
- R2: Operation code 2'b00 (bus reset) pulls the line low for the first 480 microsecond ticks after acceptance, then releases it. The operation ends on the 960th tick.
- R3: During a bus reset, the line is sampled on the tick at which 550 ticks have elapsed (70 after release). `presence` becomes 1 if the line was low there and 0 if it was high.
- R4: Operation code 2'b01 with `req_wbit`=1 pulls the line low for 6 ticks. The slot ends on the 70th tick.
- R5: Operation code 2'b01 with `req_wbit`=0 pulls the line low for 60 ticks. The slot ends on the 70th tick.
- R6: Operation code 2'b10 (read) pulls the line low for 6 ticks and samples the line when 15 ticks have elapsed. `rd_bit` takes the sampled level (low gives 0, high gives 1). The slot ends on the 70th tick.
- R7: `done` is high for exactly one clock, in the cycle right after the final tick. `busy` is low in that same cycle.
- R8: A request is accepted only while `busy` is low. Requests made while busy have no effect on the running operation or its results. Operation code 2'b11 is never accepted.
- R9: `presence` changes only during a bus reset, and `rd_bit` changes only during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| req_valid | input | 1 | Operation request strobe |
| req_op | input | 2 | 00 bus reset, 01 write, 10 read, 11 no operation |
| req_wbit | input | 1 | Bit value for a write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock pulse at completion |
| rd_bit | output | 1 | Bit captured by the latest read |
| presence | output | 1 | Device detected by the latest bus reset |
| line_oe | output | 1 | Pull the wire low when 1 |
| line_in | input | 1 | Sampled wire level |

## Verification
A corrupted tick count or a wrong latched operation shows up first on `line_oe`. The release edge moves off its expected tick, and this can be seen within the low window of the current slot, so within 6 to 480 microseconds. A wrong end compare moves `done` away from the 70th or 960th tick. A sample taken at the wrong point, or from the wrong operation, appears on `presence` or `rd_bit` at the next `done`. The bench's slave model changes its hold times so that such a shift flips the captured value.

// File: rtl/owm_pkg.sv
package owm_pkg;
  typedef enum logic [1:0] {
    OP_BUSRST = 2'b00,
    OP_WRITE  = 2'b01,
    OP_READ   = 2'b10,
    OP_NONE   = 2'b11
  } owm_op_e;

  // Ticks during which the master pulls the line low.
  function automatic int unsigned pull_ticks(owm_op_e op, logic wbit,
      int unsigned rst_low, int unsigned w0_low, int unsigned w1_low,
      int unsigned rd_low);
    case (op)
      OP_BUSRST: return rst_low;
      OP_WRITE:  return wbit ? w1_low : w0_low;
      OP_READ:   return rd_low;
      default:   return 0;
    endcase
  endfunction

  // Total ticks from acceptance to completion.
  function automatic int unsigned span_ticks(owm_op_e op,
      int unsigned rst_low, int unsigned rst_listen, int unsigned slot);
    return (op == OP_BUSRST) ? rst_low + rst_listen : slot;
  endfunction

  // Elapsed tick count at which the line is sampled.
  function automatic int unsigned probe_tick(owm_op_e op,
      int unsigned rst_low, int unsigned pres_off, int unsigned rd_smp);
    return (op == OP_BUSRST) ? rst_low + pres_off : rd_smp;
  endfunction
endpackage

// File: rtl/owm_tick_counter.sv
module owm_tick_counter #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          advance,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (clear)   count <= '0;
    else if (advance) count <= count + 1'b1;
  end
endmodule

// File: rtl/owm_ctrl.sv
module owm_ctrl
  import owm_pkg::*;
#(
  parameter int CW         = 10,
  parameter int RST_LOW    = 480,
  parameter int RST_LISTEN = 480,
  parameter int PRES_OFF   = 70,
  parameter int W0_LOW     = 60,
  parameter int W1_LOW     = 6,
  parameter int RD_LOW     = 6,
  parameter int RD_SMP     = 15,
  parameter int SLOT       = 70
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          us_tick,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic          req_wbit,
  input  logic [CW-1:0] count,
  output logic          cnt_clear,
  output logic          cnt_adv,
  output logic          busy,
  output logic          done,
  output logic          line_oe,
  output logic          pres_evt,
  output logic          bit_evt
);
  owm_op_e op_q;
  logic    wbit_q;
  logic    accept, end_evt, smp_evt;
  logic [CW-1:0] low_lim, end_pt, smp_pt;

  assign low_lim = CW'(pull_ticks(op_q, wbit_q, RST_LOW, W0_LOW, W1_LOW, RD_LOW));
  assign end_pt  = CW'(span_ticks(op_q, RST_LOW, RST_LISTEN, SLOT) - 1);
  assign smp_pt  = CW'(probe_tick(op_q, RST_LOW, PRES_OFF, RD_SMP));

  assign accept    = req_valid && !busy && (owm_op_e'(req_op) != OP_NONE);
  assign cnt_clear = accept;
  assign cnt_adv   = busy && us_tick;
  assign end_evt   = cnt_adv && (count == end_pt);
  assign smp_evt   = cnt_adv && (count == smp_pt);
  assign pres_evt  = smp_evt && (op_q == OP_BUSRST);
  assign bit_evt   = smp_evt && (op_q == OP_READ);
  assign line_oe   = busy && (count < low_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      op_q   <= OP_BUSRST;
      wbit_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        op_q   <= owm_op_e'(req_op);
        wbit_q <= req_wbit;
      end else if (end_evt) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/owm_sampler.sv
module owm_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic pres_evt,
  input  logic bit_evt,
  output logic presence,
  output logic rd_bit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presence <= 1'b0;
      rd_bit   <= 1'b0;
    end else begin
      if (pres_evt) presence <= ~line_in;
      if (bit_evt)  rd_bit   <= line_in;
    end
  end
endmodule

// File: rtl/owire_slot_master.sv
module owire_slot_master #(
  parameter int RST_LOW    = 480,
  parameter int RST_LISTEN = 480,
  parameter int PRES_OFF   = 70,
  parameter int W0_LOW     = 60,
  parameter int W1_LOW     = 6,
  parameter int RD_LOW     = 6,
  parameter int RD_SMP     = 15,
  parameter int SLOT       = 70
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       us_tick,
  input  logic       req_valid,
  input  logic [1:0] req_op,
  input  logic       req_wbit,
  output logic       busy,
  output logic       done,
  output logic       rd_bit,
  output logic       presence,
  output logic       line_oe,
  input  logic       line_in
);
  localparam int LONGEST = (RST_LOW + RST_LISTEN > SLOT) ? RST_LOW + RST_LISTEN : SLOT;
  localparam int CW      = $clog2(LONGEST + 1);

  logic [CW-1:0] count;
  logic          cnt_clear, cnt_adv, pres_evt, bit_evt;

  owm_tick_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(cnt_clear), .advance(cnt_adv), .count(count)
  );

  owm_ctrl #(
    .CW(CW), .RST_LOW(RST_LOW), .RST_LISTEN(RST_LISTEN), .PRES_OFF(PRES_OFF),
    .W0_LOW(W0_LOW), .W1_LOW(W1_LOW), .RD_LOW(RD_LOW), .RD_SMP(RD_SMP), .SLOT(SLOT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .req_valid(req_valid),
    .req_op(req_op), .req_wbit(req_wbit), .count(count),
    .cnt_clear(cnt_clear), .cnt_adv(cnt_adv), .busy(busy), .done(done),
    .line_oe(line_oe), .pres_evt(pres_evt), .bit_evt(bit_evt)
  );

  owm_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .pres_evt(pres_evt),
    .bit_evt(bit_evt), .presence(presence), .rd_bit(rd_bit)
  );
endmodule

// File: rtl/owm_checker.sv
module owm_checker (
  input logic clk,
  input logic rst_n,
  input logic us_tick,
  input logic req_valid,
  input logic busy,
  input logic done,
  input logic line_oe,
  input logic presence,
  input logic rd_bit,
  input logic pres_evt,
  input logic bit_evt
);
  p_oe_needs_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe |-> busy);
  p_release_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_oe) |-> $past(us_tick));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_ends_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  p_start_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));
  p_pres_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pres_evt |=> $stable(presence));
  p_bit_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_evt |=> $stable(rd_bit));
endmodule

bind owire_slot_master owm_checker u_owm_chk (
  .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .req_valid(req_valid),
  .busy(busy), .done(done), .line_oe(line_oe), .presence(presence),
  .rd_bit(rd_bit), .pres_evt(pres_evt), .bit_evt(bit_evt)
);

// File: tb/owire_slot_master_bench.sv
`timescale 1ns/1ps
module owire_slot_master_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic us_tick = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'b00;
  logic req_wbit = 1'b0;
  logic busy, done, rd_bit, presence, line_oe, line_in;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // slave model settings
  int  s_mode = 0;      // 0 silent, 1 presence pulse, 2 hold low from slot start
  int  s_wait = 20;
  int  s_dur  = 100;
  int  s_hold = 30;
  int  bcnt   = 0;
  bit  b_active = 1'b0;
  logic slave_low;

  always #2.5 clk = ~clk;

  owire_slot_master u_owire_slot_master (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .req_valid(req_valid),
    .req_op(req_op), .req_wbit(req_wbit), .busy(busy), .done(done),
    .rd_bit(rd_bit), .presence(presence), .line_oe(line_oe), .line_in(line_in)
  );

  always_comb begin
    slave_low = 1'b0;
    if (b_active && s_mode == 1)
      slave_low = (bcnt >= 480 + s_wait) && (bcnt < 480 + s_wait + s_dur);
    else if (b_active && s_mode == 2)
      slave_low = (bcnt < s_hold);
  end
  assign line_in = !(line_oe || slave_low);

  // microsecond tick: one clock in four
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      us_tick = 1'b1;
      @(negedge clk);
      us_tick = 1'b0;
    end
  end

  // bench timeline: ticks since acceptance
  always @(posedge clk) begin
    if (req_valid && !busy && req_op != 2'b11) begin
      bcnt <= 0; b_active <= 1'b1;
    end else if (b_active && us_tick) begin
      bcnt <= bcnt + 1;
    end
  end

  function automatic int exp_low(int op, bit wb);
    if (op == 0) return 480;
    if (op == 1) return wb ? 6 : 60;
    return 6;
  endfunction
  function automatic int exp_total(int op);
    return (op == 0) ? 960 : 70;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // op: 0 reset, 1 write, 2 read; poke: inject a request mid-slot
  task automatic run_op(int op, bit wb, bit poke, string tag);
    int oe_bad = 0;
    int k = 0;
    bit pres_before = presence;
    bit bit_before = rd_bit;
    bit exp_p = presence;
    bit exp_b = rd_bit;
    if (op == 0) exp_p = (s_mode == 1);
    if (op == 2) exp_b = !(s_mode == 2 && s_hold > 15);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_wbit = wb;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) begin
      if (line_oe !== (bcnt < exp_low(op, wb))) oe_bad++;
      if (poke && k == 20) begin
        req_valid = 1'b1; req_op = 2'b00; req_wbit = !wb;
      end else begin
        req_valid = 1'b0;
      end
      k++;
      if (k > 8000) break;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(oe_bad == 0, {tag, " line drive window"}, oe_bad, 0);
    chk(bcnt == exp_total(op) && !busy, {"R7 end tick ", tag}, bcnt, exp_total(op));
    chk(presence == exp_p, {"R3/R9 presence ", tag}, presence, exp_p);
    chk(rd_bit == exp_b, {"R6/R9 rd_bit ", tag}, rd_bit, exp_b);
    if (poke) chk(bcnt == exp_total(op), "R8 busy request ignored", bcnt, exp_total(op));
    @(negedge clk);
    b_active = 1'b0;
    chk(!done, "R7 done width", done, 0);
    if (op != 0) chk(presence == pres_before, "R9 presence kept", presence, pres_before);
    if (op != 2) chk(rd_bit == bit_before, "R9 rd_bit kept", rd_bit, bit_before);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1993));
    repeat (5) @(negedge clk);
    chk(!busy && !done && !line_oe && !presence && !rd_bit, "R1 reset state",
        {busy, done, line_oe, presence, rd_bit}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    s_mode = 1; s_wait = 15; s_dur = 60;  run_op(0, 0, 0, "R2 R3 reset present short");
    s_mode = 0;                           run_op(0, 0, 0, "R2 R3 reset absent");
    s_mode = 1; s_wait = 60; s_dur = 240; run_op(0, 0, 0, "R2 R3 reset present long");
    s_mode = 0;                           run_op(1, 1, 0, "R4 write1");
    s_mode = 0;                           run_op(1, 0, 0, "R5 write0");
    s_mode = 2; s_hold = 30;              run_op(2, 0, 0, "R6 read zero");
    s_mode = 0;                           run_op(2, 0, 0, "R6 read one");
    s_mode = 2; s_hold = 14;              run_op(2, 0, 0, "R6 read short hold");
    s_mode = 2; s_hold = 16;              run_op(2, 0, 1, "R8 R6 read with poke");

    // R8: code 11 never accepted
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'b11;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (40) @(negedge clk);
    chk(!busy && !line_oe && !done, "R8 code 11 ignored", {busy, line_oe, done}, 0);

    for (int i = 0; i < 30; i++) begin
      int op = ($urandom % 8 == 0) ? 0 : 1 + ($urandom % 2);
      s_mode = $urandom % 3;
      if (op == 0 && s_mode == 2) s_mode = 0;
      if (op != 0 && s_mode == 1) s_mode = 2;
      s_wait = 15 + ($urandom % 46);
      s_dur  = 60 + ($urandom % 181);
      s_hold = 10 + ($urandom % 40);
      run_op(op, 1'($urandom), 1'($urandom % 4 == 0), "random");
    end
    finish_run();
  end
endmodule